// File: doc/BRIEF.md
# Single-Wire Bus Real-Time-Clock Command Handler

This block sits above a bit-level link layer in a single-wire bus slave and gives meaning to the bytes it receives. It keeps a seconds counter and an 8-bit control byte. A 1 Hz tick advances the counter while the oscillator bits of the control byte enable it. After each bus reset pulse the first byte is taken as a command. One command code starts a read of the clock. Another starts a write of the clock. Any other code silences the block until the next reset pulse.

A read takes a snapshot of the control byte and the live counter into a five-entry transfer buffer, in the same cycle the command byte strobe arrives. The master then draws bytes one at a time through a read-request strobe. The bytes come back in a fixed order and repeat from that snapshot. A write takes the control byte at once. It stages the time bytes in the same buffer and moves them into the counter only when the next reset pulse arrives, and only if the write was complete. The ROM layer, slot timing and the pad are outside this block.

Top module: `rtc_cmd_layer`

## Requirements
- R1: After a bus reset pulse, a received byte 0x66 enters read mode (`rd_active` high on the next cycle), and 0x99 enters write mode (`rd_active` stays low).
- R2: On the 0x66 strobe, the control byte and the counter are copied into the transfer buffer. Ticks that arrive later do not change the bytes returned by that read, although `seconds` keeps advancing.
- R3: Read data order is: control byte, then counter bits [7:0], [15:8], [23:16], [31:24]. `tx_byte` shows the byte to send, and each `tx_req` moves on to the next one.
- R4: A `tx_req` on the fifth byte wraps the read back to the control byte, and the same snapshot values are returned again.
- R5: A bus reset pulse ends a read or a write at any byte position. On the next cycle `rd_active` is low and `tx_byte` is 0xFF.
- R6: In write mode the first data byte replaces the control byte on the next cycle. `osc_run` follows it at once.
- R7: The next four write bytes are time bytes, least significant first. `seconds` keeps its value until the next bus reset pulse, and on the cycle after that pulse it holds the written value.
- R8: A write that stops before all four time bytes leaves `seconds` unchanged at the next reset pulse.
- R9: `osc_run` is high exactly when control bits [3:2] are 2'b11. While it is high, each tick adds one to `seconds`. While it is low, `seconds` holds its value.
- R10: A command byte other than 0x66 or 0x99 makes the block ignore every later byte, including 0x66 and 0x99, until the next bus reset pulse.
- R11: After `rst`, `seconds` and `ctrl_byte` are zero, `rd_active` is low and `tx_byte` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle indication of a bus reset pulse |
| rx_valid | input | 1 | Received-byte strobe from the link layer |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Link layer has sent `tx_byte`; advance to the next byte |
| tx_byte | output | 8 | Byte to transmit next (0xFF when not reading) |
| rd_active | output | 1 | Read-clock transfer in progress |
| tick_1hz | input | 1 | One-cycle seconds tick |
| osc_run | output | 1 | Oscillator enabled by the control byte |
| ctrl_byte | output | 8 | Current control byte |
| seconds | output | 8*CNT_BYTES | Live seconds counter |

## Verification
The bench builds the block with its defaults: a four-byte counter and a five-entry transfer buffer. This puts the wrap at the fifth read byte within reach, as well as a time commit on the reset pulse and a partial write that falls one or more bytes short of the full length. Counter values are chosen with distinct bytes so that any byte-order fault shows up. Ticks are placed between a snapshot and its read, so that a buffer that tracks the live counter is caught.

// File: rtl/rtc_cmd_pkg.sv
package rtc_cmd_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_READ,
        PH_WRITE,
        PH_MUTE
    } phase_e;

    localparam byte_t CODE_READ  = 8'h66;
    localparam byte_t CODE_WRITE = 8'h99;
    localparam byte_t TX_IDLE    = 8'hFF;
    localparam int unsigned OSC_LSB = 2;

    function automatic phase_e decode_cmd(input byte_t code);
        case (code)
            CODE_READ:  return PH_READ;
            CODE_WRITE: return PH_WRITE;
            default:    return PH_MUTE;
        endcase
    endfunction

    function automatic logic osc_enabled(input byte_t c);
        return c[OSC_LSB+1 -: 2] == 2'b11;
    endfunction

endpackage

// File: rtl/rtc_cmd_seq.sv
module rtc_cmd_seq
    import rtc_cmd_pkg::*;
#(
    parameter int unsigned BUF_LEN = 5,
    localparam int unsigned PTR_W = $clog2(BUF_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             rx_valid,
    input  byte_t            rx_byte,
    input  logic             tx_req,
    output phase_e           phase,
    output logic [PTR_W-1:0] ptr,
    output logic             snap,
    output logic             wr_we,
    output logic             ctrl_we,
    output logic             commit
);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(BUF_LEN);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BUF_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            phase <= PH_CMD;
            ptr   <= '0;
        end else begin
            case (phase)
                PH_CMD: if (rx_valid) begin
                    phase <= decode_cmd(rx_byte);
                    ptr   <= '0;
                end
                PH_READ: if (tx_req) begin
                    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
                end
                PH_WRITE: if (rx_valid && ptr != FULL) begin
                    ptr <= ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        snap    = !bus_reset && phase == PH_CMD && rx_valid && rx_byte == CODE_READ;
        wr_we   = !bus_reset && phase == PH_WRITE && rx_valid && ptr != FULL;
        ctrl_we = wr_we && ptr == '0;
        commit  = bus_reset && phase == PH_WRITE && ptr == FULL;
    end

endmodule

// File: rtl/rtc_xfer_buf.sv
module rtc_xfer_buf
    import rtc_cmd_pkg::*;
#(
    parameter int unsigned BUF_LEN = 5,
    localparam int unsigned PTR_W = $clog2(BUF_LEN + 1),
    localparam int unsigned TW = 8 * (BUF_LEN - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snap,
    input  byte_t            snap_ctrl,
    input  logic [TW-1:0]    snap_time,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  byte_t            wdata,
    input  logic [PTR_W-1:0] raddr,
    output byte_t            rdata,
    output logic [TW-1:0]    time_out
);
    byte_t mem [BUF_LEN];

    for (genvar i = 0; i < BUF_LEN; i++) begin : g_ent
        byte_t snap_val;
        if (i == 0) begin : g_ctl
            assign snap_val = snap_ctrl;
        end else begin : g_tim
            assign snap_val = snap_time[(i-1)*8 +: 8];
            assign time_out[(i-1)*8 +: 8] = mem[i];
        end
        always_ff @(posedge clk) begin
            if (rst)                                    mem[i] <= '0;
            else if (snap)                              mem[i] <= snap_val;
            else if (we && waddr == PTR_W'(i))          mem[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < BUF_LEN; i++)
            if (raddr == PTR_W'(i)) rdata = mem[i];
    end

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)              count <= '0;
        else if (load)        count <= load_val;
        else if (tick && run) count <= count + 1'b1;
    end
endmodule

// File: rtl/rtc_cmd_layer.sv
module rtc_cmd_layer
    import rtc_cmd_pkg::*;
#(
    parameter int unsigned CNT_BYTES = 4,
    localparam int unsigned CW = 8 * CNT_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_reset,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          tx_req,
    output logic [7:0]    tx_byte,
    output logic          rd_active,
    input  logic          tick_1hz,
    output logic          osc_run,
    output logic [7:0]    ctrl_byte,
    output logic [CW-1:0] seconds
);
    localparam int unsigned BUF_LEN = CNT_BYTES + 1;
    localparam int unsigned PTR_W   = $clog2(BUF_LEN + 1);

    phase_e           phase;
    logic [PTR_W-1:0] ptr;
    logic             snap, wr_we, ctrl_we, commit;
    byte_t            buf_rd;
    logic [CW-1:0]    staged_time;

    rtc_cmd_seq #(.BUF_LEN(BUF_LEN)) u_seq (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .phase(phase), .ptr(ptr), .snap(snap), .wr_we(wr_we),
        .ctrl_we(ctrl_we), .commit(commit)
    );

    rtc_xfer_buf #(.BUF_LEN(BUF_LEN)) u_buf (
        .clk(clk), .rst(rst), .snap(snap),
        .snap_ctrl(ctrl_byte), .snap_time(seconds),
        .we(wr_we), .waddr(ptr), .wdata(rx_byte),
        .raddr(ptr), .rdata(buf_rd), .time_out(staged_time)
    );

    always_ff @(posedge clk) begin
        if (rst)          ctrl_byte <= '0;
        else if (ctrl_we) ctrl_byte <= rx_byte;
    end

    assign osc_run = osc_enabled(ctrl_byte);

    rtc_sec_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_1hz), .run(osc_run),
        .load(commit), .load_val(staged_time), .count(seconds)
    );

    assign rd_active = phase == PH_READ;
    assign tx_byte   = rd_active ? buf_rd : TX_IDLE;

endmodule

// File: rtl/rtc_cmd_layer_chk.sv
module rtc_cmd_layer_chk #(
    parameter int unsigned CNT_BYTES = 4,
    localparam int unsigned CW = 8 * CNT_BYTES
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_reset,
    input logic          rx_valid,
    input logic [7:0]    rx_byte,
    input logic          tx_req,
    input logic [7:0]    tx_byte,
    input logic          rd_active,
    input logic          tick_1hz,
    input logic          osc_run,
    input logic [7:0]    ctrl_byte,
    input logic [CW-1:0] seconds
);
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!osc_run && !bus_reset) |=> seconds == $past(seconds));

    p_tick_inc_r9: assert property (@(posedge clk) disable iff (rst)
        (osc_run && tick_1hz && !bus_reset) |=> seconds == $past(seconds) + 1'b1);

    p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !bus_reset) |=> seconds == $past(seconds));

    p_reset_ends_r5: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (!rd_active && tx_byte == 8'hFF));

    p_snap_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_active && !tx_req && !bus_reset) |=> $stable(tx_byte));

    p_ctrl_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(ctrl_byte));

    p_ctrl_src_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_byte != $past(ctrl_byte)) |-> ctrl_byte == $past(rx_byte));

endmodule

bind rtc_cmd_layer rtc_cmd_layer_chk #(.CNT_BYTES(CNT_BYTES)) u_chk (.*);

// File: tb/rtc_cmd_layer_test.sv
module rtc_cmd_layer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_req = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [7:0]  tx_byte;
    logic        rd_active;
    logic        osc_run;
    logic [7:0]  ctrl_byte;
    logic [31:0] seconds;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_cmd_layer uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte),
        .rd_active(rd_active), .tick_1hz(tick_1hz), .osc_run(osc_run),
        .ctrl_byte(ctrl_byte), .seconds(seconds)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1 rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        @(posedge clk); #1 bus_reset = 1'b1;
        @(posedge clk); #1 bus_reset = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1 tick_1hz = 1'b1;
        @(posedge clk); #1 tick_1hz = 1'b0;
    endtask

    // Driver: queue expected bytes, then request them.
    task automatic read_bytes(input logic [7:0] ctl, input logic [31:0] t, input int n);
        for (int k = 0; k < n; k++) begin
            int pos = k % 5;
            expq.push_back(pos == 0 ? ctl : t[(pos-1)*8 +: 8]);
        end
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1 tx_req = 1'b1;
            @(posedge clk); #1 tx_req = 1'b0;
        end
    endtask

    // Monitor: compare each consumed byte with the scoreboard (R2 R3 R4).
    always @(negedge clk) begin
        if (tx_req) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R3 unexpected read: actual %h expected none", tx_byte);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                if (tx_byte !== e) begin
                    fails++;
                    $display("FAIL R3/R4 read byte: actual %h expected %h", tx_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11 reset state
        chk("R11 seconds", seconds, 0);
        chk("R11 ctrl", {24'h0, ctrl_byte}, 0);
        chk("R11 rd_active", {31'h0, rd_active}, 0);
        chk("R11 tx_byte", {24'h0, tx_byte}, 32'hFF);

        // Full write: R1, R6, R7
        pulse_reset();
        send_byte(8'h99);
        chk("R1 write no read", {31'h0, rd_active}, 0);
        send_byte(8'h0C);
        chk("R6 ctrl immediate", {24'h0, ctrl_byte}, 32'h0C);
        chk("R6 osc on", {31'h0, osc_run}, 1);
        send_byte(8'h78); send_byte(8'h56); send_byte(8'h34); send_byte(8'h12);
        chk("R7 before reset", seconds, 0);
        pulse_reset();
        chk("R7 commit", seconds, 32'h12345678);

        // R9 running
        tick(); tick(); tick();
        chk("R9 ticks", seconds, 32'h1234567B);

        // Snapshot read with ticks after it: R1, R2, R3, R4
        pulse_reset();
        send_byte(8'h66);
        chk("R1 read mode", {31'h0, rd_active}, 1);
        tick(); tick();
        chk("R2 live counter", seconds, 32'h1234567D);
        read_bytes(8'h0C, 32'h1234567B, 11);

        // R5 reset mid-read
        pulse_reset();
        send_byte(8'h66);
        read_bytes(8'h0C, 32'h1234567D, 2);
        pulse_reset();
        chk("R5 rd_active", {31'h0, rd_active}, 0);
        chk("R5 tx idle", {24'h0, tx_byte}, 32'hFF);

        // Partial write, stop oscillator: R6, R8, R9
        send_byte(8'h99);
        send_byte(8'h00);
        chk("R6 osc off", {31'h0, osc_run}, 0);
        send_byte(8'h11); send_byte(8'h22);
        pulse_reset();
        chk("R8 partial", seconds, 32'h1234567D);
        tick();
        chk("R9 stopped", seconds, 32'h1234567D);

        // Unknown command: R10, then recovery R1
        pulse_reset();
        send_byte(8'h55);
        send_byte(8'h66);
        chk("R10 no read", {31'h0, rd_active}, 0);
        send_byte(8'h99); send_byte(8'h0C);
        chk("R10 ctrl kept", {24'h0, ctrl_byte}, 0);
        pulse_reset();
        send_byte(8'h66);
        chk("R1 read after mute", {31'h0, rd_active}, 1);
        read_bytes(8'h00, 32'h1234567D, 5);
        pulse_reset();

        repeat (2) @(posedge clk);
        chk("R3 scoreboard drained", expq.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule